// File: doc/BRIEF.md
# Level Interrupt Aggregator with Cause and Mask Registers

This block gathers thirty-two level-sensitive interrupt inputs into a single upstream interrupt request. Each input owns one bit in a cause register and one bit in a mask register. Bit n of both registers belongs to input n.

A cause bit is set on every clock in which its input is high. Software clears a cause bit by writing a one to it, which acknowledges that input. An input that is still high after the acknowledge sets its bit again at once, because the inputs are levels and not edges. Software enables or disables an input by rewriting the whole 32-bit mask word.

An input counts as pending only when both its cause bit and its mask bit are one. The upstream request is high whenever any input is pending. The block also reports the lowest-numbered pending input, with a flag that marks that report valid.

Software reaches the two registers through a plain word-wide register port made of an address, a write strobe, write data and read data. To quiesce the block, software writes zero to the mask and then all ones to the cause register.

Top module: `lirq_agg`

## Requirements
- R1: On each clock, every input that is high sets its cause bit. A cause bit never becomes one unless its input was high in the previous cycle.
- R2: A write to offset 0x00 clears each cause bit whose write-data bit is 1. Cause bits whose write-data bit is 0 keep their value.
- R3: When an input is high in the same cycle that a write to offset 0x00 clears its bit, the bit ends up set.
- R4: A write to offset 0x04 loads the whole 32-bit mask word. The mask changes at no other time, and a read of offset 0x04 returns the mask.
- R5: `irq_o` is a register output. Its value always equals the OR of all bits of (cause AND mask).
- R6: `pend_vld_o` is high exactly when (cause AND mask) is non-zero. While it is high, `pend_idx_o` is the bit position of the least significant one in (cause AND mask).
- R7: Right after reset, cause and mask are all zeros, and `irq_o` and `pend_vld_o` are low.
- R8: Reads of any offset other than 0x00 and 0x04 return zero. Writes to such offsets change neither register.
- R9: With every input low, writing zero to the mask and then all ones to the cause register leaves both registers at zero and `irq_o` low.
- R10: A masked input still records its cause bit, but it raises neither `irq_o` nor `pend_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level interrupt inputs; bit n is input n |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe for the current offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current offset (combinational) |
| irq_o | output | 1 | Upstream interrupt request |
| pend_idx_o | output | 5 | Index of the lowest pending input |
| pend_vld_o | output | 1 | High when any input is pending |

## Verification
The assertions check the following on every cycle:
- `irq_o` and `pend_vld_o` agree with the cause and mask registers.
- `pend_idx_o` points at the lowest pending bit.
- No cause bit appears without a high input one cycle earlier.
- Every high input shows up in the cause register one cycle later.
- The mask holds whenever no write to its offset occurs.

Some behaviours only the bench scenarios can show, because they depend on a sequence of register operations and on data values. These are:
- An acknowledge that only partly clears the cause register.
- A write of zeros that leaves the cause register unchanged.
- An input that stays high across its own acknowledge.
- Writes that fall outside the two registers.
- The two-step quiesce sequence.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    // Shared sizes and register offsets for the level interrupt aggregator.
    localparam int unsigned NSRC_DEF   = 32;
    localparam int unsigned ADDR_W_DEF = 8;
    localparam logic [7:0]  OFF_CAUSE  = 8'h00;
    localparam logic [7:0]  OFF_MASK   = 8'h04;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/lirq_bus_dec.sv
module lirq_bus_dec
    import lirq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DATA_W = NSRC_DEF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] cause_q_i,
    input  logic [DATA_W-1:0] mask_q_i,
    output logic              cause_we_o,
    output logic              mask_we_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_sel_e sel;

    always_comb begin
        if (addr_i == ADDR_W'(OFF_CAUSE))      sel = SEL_CAUSE;
        else if (addr_i == ADDR_W'(OFF_MASK))  sel = SEL_MASK;
        else                                   sel = SEL_NONE;
    end

    always_comb begin
        cause_we_o = 1'b0;
        mask_we_o  = 1'b0;
        rdata_o    = '0;
        unique case (sel)
            SEL_CAUSE: begin
                cause_we_o = we_i;
                rdata_o    = cause_q_i;
            end
            SEL_MASK: begin
                mask_we_o = we_i;
                rdata_o   = mask_q_i;
            end
            default: begin
                rdata_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/lirq_cause_reg.sv
module lirq_cause_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            clr_en_i,
    input  logic [NSRC-1:0] clr_bits_i,
    output logic [NSRC-1:0] cause_d_o,
    output logic [NSRC-1:0] cause_q_o
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_bit
            logic clr_hit;
            assign clr_hit = clr_en_i & clr_bits_i[g];
            // a high input outranks an acknowledge in the same cycle
            assign cause_d_o[g] = src_i[g] | (cause_q_o[g] & ~clr_hit);

            always_ff @(posedge clk) begin
                if (!rst_n) cause_q_o[g] <= 1'b0;
                else        cause_q_o[g] <= cause_d_o[g];
            end
        end
    endgenerate
endmodule

// File: rtl/lirq_mask_reg.sv
module lirq_mask_reg #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_d_o,
    output logic [NSRC-1:0] mask_q_o
);
    assign mask_d_o = we_i ? wdata_i : mask_q_o;

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q_o <= '0;
        else        mask_q_o <= mask_d_o;
    end
endmodule

// File: rtl/lirq_lowest.sv
module lirq_lowest #(
    parameter int unsigned NSRC  = 32,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             vld_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign vld_o = |vec_i;
endmodule

// File: rtl/lirq_agg.sv
module lirq_agg
    import lirq_pkg::*;
#(
    parameter int unsigned NSRC   = NSRC_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    localparam int unsigned IDX_W = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [NSRC-1:0]   bus_wdata_i,
    output logic [NSRC-1:0]   bus_rdata_o,
    output logic              irq_o,
    output logic [IDX_W-1:0]  pend_idx_o,
    output logic              pend_vld_o
);
    logic [NSRC-1:0] cause_q, cause_d;
    logic [NSRC-1:0] mask_q, mask_d;
    logic            cause_we, mask_we;
    logic            irq_q;

    lirq_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(NSRC)) u_dec (
        .addr_i     (bus_addr_i),
        .we_i       (bus_we_i),
        .cause_q_i  (cause_q),
        .mask_q_i   (mask_q),
        .cause_we_o (cause_we),
        .mask_we_o  (mask_we),
        .rdata_o    (bus_rdata_o)
    );

    lirq_cause_reg #(.NSRC(NSRC)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .clr_en_i   (cause_we),
        .clr_bits_i (bus_wdata_i),
        .cause_d_o  (cause_d),
        .cause_q_o  (cause_q)
    );

    lirq_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (mask_we),
        .wdata_i  (bus_wdata_i),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    lirq_lowest #(.NSRC(NSRC)) u_low (
        .vec_i (cause_q & mask_q),
        .idx_o (pend_idx_o),
        .vld_o (pend_vld_o)
    );

    // registered request built from next-state values so it tracks cause&mask
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_d & mask_d);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/lirq_agg_chk.sv
module lirq_agg_chk #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [NSRC-1:0]   cause_q,
    input logic [NSRC-1:0]   mask_q,
    input logic              irq_o,
    input logic [IDX_W-1:0]  pend_idx_o,
    input logic              pend_vld_o
);
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] below;
    assign pend  = cause_q & mask_q;
    assign below = (NSRC'(1) << pend_idx_o) - NSRC'(1);

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|pend)); // R5

    AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o == (|pend)); // R6

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o |-> (pend[pend_idx_o] && ((pend & below) == '0))); // R6

    AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(src_i)) == $past(src_i))); // R3

    AST_NO_SPURIOUS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(src_i)) == '0)); // R1

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we_i && bus_addr_i == ADDR_W'(8'h04)) |=> $stable(mask_q)); // R4
endmodule

bind lirq_agg lirq_agg_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .bus_addr_i (bus_addr_i),
    .bus_we_i   (bus_we_i),
    .cause_q    (cause_q),
    .mask_q     (mask_q),
    .irq_o      (irq_o),
    .pend_idx_o (pend_idx_o),
    .pend_vld_o (pend_vld_o)
);

// File: tb/sim_lirq_agg.sv
`timescale 1ns/1ps
module sim_lirq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [4:0]  idx;
    logic        vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lirq_agg u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .pend_idx_o(idx), .pend_vld_o(vld)
    );

    // behavioural reference model
    logic [31:0] m_cause = '0;
    logic [31:0] m_mask  = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cause <= '0;
            m_mask  <= '0;
        end else begin
            logic [31:0] nc;
            nc = m_cause;
            if (we && addr == 8'h00) nc = nc & ~wdata;
            m_cause <= nc | src;
            if (we && addr == 8'h04) m_mask <= wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [31:0] p;
        logic [31:0] exp_rd;
        int lo;
        p = m_cause & m_mask;
        lo = 0;
        for (int i = 31; i >= 0; i--) if (p[i]) lo = i;
        if (addr == 8'h00)      exp_rd = m_cause;
        else if (addr == 8'h04) exp_rd = m_mask;
        else                    exp_rd = 32'h0;
        chk("R8 rdata vs model", rdata, exp_rd);
        chk("R5 irq vs model", {31'd0, irq}, {31'd0, |p});
        chk("R6 vld vs model", {31'd0, vld}, {31'd0, |p});
        if (p != 0) chk("R6 idx vs model", {27'd0, idx}, 32'(lo));
    endtask

    // compare at the falling edge, then drive the next cycle's inputs
    task automatic step(input logic [7:0] a, input logic w, input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        if (rst_n) compare_model();
        addr = a; we = w; wdata = d; src = s;
    endtask

    task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
        step(a, 1'b0, 32'h0, 32'h0);
        #0.5;
        chk(tag, rdata, exp);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        peek(8'h00, 32'h0, "R7 cause after reset");
        peek(8'h04, 32'h0, "R7 mask after reset");
        chk("R7 irq after reset", {31'd0, irq}, 32'd0);
        chk("R7 vld after reset", {31'd0, vld}, 32'd0);

        // R1 / R10: masked input records cause, no request
        step(8'h00, 1'b0, 32'h0, 32'h0000_0020);
        peek(8'h00, 32'h0000_0020, "R1 cause latched from input 5");
        chk("R10 irq low while masked", {31'd0, irq}, 32'd0);
        chk("R10 vld low while masked", {31'd0, vld}, 32'd0);

        // R4: mask load and readback
        step(8'h04, 1'b1, 32'h0000_0120, 32'h0);
        peek(8'h04, 32'h0000_0120, "R4 mask readback");
        chk("R5 irq raised", {31'd0, irq}, 32'd1);
        chk("R6 idx is 5", {27'd0, idx}, 32'd5);

        // R6: lowest index wins with two pending
        step(8'h00, 1'b0, 32'h0, 32'h0000_0100);
        peek(8'h00, 32'h0000_0120, "R1 cause with inputs 5 and 8");
        chk("R6 idx stays lowest", {27'd0, idx}, 32'd5);

        // R2: partial acknowledge, then zero write
        step(8'h00, 1'b1, 32'h0000_0020, 32'h0);
        peek(8'h00, 32'h0000_0100, "R2 ack clears bit 5 only");
        chk("R6 idx moves to 8", {27'd0, idx}, 32'd8);
        step(8'h00, 1'b1, 32'h0, 32'h0);
        peek(8'h00, 32'h0000_0100, "R2 zero write keeps cause");

        // R3: input held high across its acknowledge
        step(8'h00, 1'b1, 32'h0000_0100, 32'h0000_0100);
        peek(8'h00, 32'h0000_0100, "R3 set beats clear");
        chk("R3 irq still high", {31'd0, irq}, 32'd1);
        step(8'h00, 1'b1, 32'h0000_0100, 32'h0);
        peek(8'h00, 32'h0, "R2 ack after input drops");
        chk("R5 irq low after ack", {31'd0, irq}, 32'd0);

        // R8: unmapped offset
        step(8'h08, 1'b1, 32'hFFFF_FFFF, 32'h0);
        peek(8'h08, 32'h0, "R8 unmapped read zero");
        peek(8'h04, 32'h0000_0120, "R8 mask untouched by unmapped write");
        peek(8'h00, 32'h0, "R8 cause untouched by unmapped write");

        // R9: quiesce sequence
        step(8'h00, 1'b0, 32'h0, 32'h0000_0041);
        step(8'h04, 1'b1, 32'h0, 32'h0);
        step(8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0);
        peek(8'h00, 32'h0, "R9 cause cleared");
        peek(8'h04, 32'h0, "R9 mask cleared");
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        // pattern sweep against the model
        for (int k = 0; k < 40; k++) begin
            step((k % 3 == 0) ? 8'h04 : 8'h00, (k % 2) == 1,
                 32'hA5A5_0000 ^ (32'h1 << (k % 32)), 32'h1 << ((k * 7) % 32));
        end
        step(8'h00, 1'b0, 32'h0, 32'h0);
        step(8'h00, 1'b0, 32'h0, 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule